// File: doc/BRIEF.md
# Timestamp Counter with Indirect Register Access

This block keeps a 96-bit real-time value that advances every clock cycle by a programmable 39-bit step. Its upper 64 bits are the timestamp output: 32 bits of whole seconds, then 32 bits of binary fraction. Software controls it over a simple 32-bit memory-mapped bus. The wide step, real-time and capture registers have no bus addresses of their own. Software stages up to 96 bits in three data words and then writes a transfer code to a control word. The code either loads a hidden register from the staging words or copies a hidden register into them.

A falling edge on the active-low pulse-per-second input captures the real-time value into a read-only capture register. A status word reports recent pulse activity and whether the counter has moved since the previous status read. Further words hold the timestamp-valid flag and the two source-select values that drive output pins, and pass through the clock-frequency code and the source counts. The bus and the counter share one clock.

Top module: `ts_counter_regs`

## Requirements
- R1: The staging words are read/write at word index 0 (bits 31:0), 1 (bits 63:32) and 2 (bits 95:64) of a 96-bit staging value. Byte address = word index × 4, and the two low address bits are ignored.
- R2: A write to word 3 (control) acts on write-data bits 2:0. Code 000 loads staging bits 38:0 into the step register. Code 001 loads the full staging value into the real-time register. Control reads as zero.
- R3: Control code 100 copies the zero-extended step into staging, 101 copies the real-time value, and 111 copies the capture register. Codes 010, 011 and 110 change nothing.
- R4: In every cycle without a code-001 load, the real-time value gains the zero-extended step modulo 2^96. A load cycle takes the staging value exactly. The timestamp output is always real-time bits 95:32.
- R5: A falling edge on the pulse input (sampled high, then low on the next edge) stores the real-time value of that cycle in the capture register. The pulse input rests high through reset.
- R6: Status (word 4) bit 0 sets on a pulse edge. It stays set for 2^ACT_WIN_LOG2 cycles after the most recent edge and then clears.
- R7: Status bit 1 is 1 when the real-time value differs from its value at the previous status read, or from zero if there has been no read since reset. The other status bits are zero.
- R8: A write to word 5 sets the timestamp-valid output to write-data bit 0. Word 5 reads as zero.
- R9: Word 6 (pulse-source select) and word 8 (clock-source select) store the low PSEL_W and CSEL_W bits of write data. They drive their outputs and read back zero-extended.
- R10: Word 7 reads the clock-frequency code input. Word 9 reads {clock-source count, pulse-source count}, with the clock count in bits 31:16. Writes to words 4, 7 and 9 have no effect.
- R11: Read data and read-valid are registered and appear exactly one cycle after the read request. Read data is zero when no read was requested or when the word index is above 9. Address-ready is always 1, and byte enables are ignored.
- R12: After reset the real-time, step, capture and staging registers are zero, and the timestamp-valid output, both selects and read-valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables (ignored) |
| bus_rdata | output | 32 | Read data |
| bus_ardy | output | 1 | Address ready, always 1 |
| bus_rvalid | output | 1 | Read data valid |
| pps_n | input | 1 | Active-low pulse-per-second input |
| pps_src_count | input | 16 | Number of pulse sources |
| clk_src_count | input | 16 | Number of clock sources |
| clk_freq_code | input | 32 | Clock frequency code (value + 1 Hz) |
| pps_sel | output | PSEL_W | Pulse source select |
| clk_sel | output | CSEL_W | Clock source select |
| ts | output | 64 | Timestamp: seconds in 63:32, fraction in 31:0 |
| ts_valid | output | 1 | Timestamp valid flag |

## Verification
A wrong step or real-time register shows on the timestamp output in the very next cycle, because every cycle adds the step. The bench therefore compares the timestamp against its own model after every clock. A corrupted staging or capture register stays hidden until software copies it out and reads it back. For that reason the directed part chains a load, a copy code and a staging read, and checks the result within three bus cycles. Errors in the activity flags appear only in status reads, so reads are placed right after an edge, after a long idle gap, and with a zero step.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned STAGE_WORDS = 3;
    localparam int unsigned STAGE_W     = DATA_W * STAGE_WORDS;
    localparam int unsigned RT_W        = STAGE_W;
    localparam int unsigned INCR_W      = 39;
    localparam int unsigned TS_W        = 64;
    localparam int unsigned CNT_W       = 16;

    // word indices (byte address / 4)
    localparam int unsigned W_STG0 = 0;
    localparam int unsigned W_CTRL = 3;
    localparam int unsigned W_STAT = 4;
    localparam int unsigned W_TSV  = 5;
    localparam int unsigned W_PSEL = 6;
    localparam int unsigned W_FREQ = 7;
    localparam int unsigned W_CSEL = 8;
    localparam int unsigned W_CNT  = 9;

    // transfer codes on control write
    localparam logic [2:0] OP_LD_INCR = 3'b000;
    localparam logic [2:0] OP_LD_RT   = 3'b001;
    localparam logic [2:0] OP_GET_INC = 3'b100;
    localparam logic [2:0] OP_GET_RT  = 3'b101;
    localparam logic [2:0] OP_GET_CAP = 3'b111;
endpackage

// File: rtl/tsc_rt_counter.sv
module tsc_rt_counter #(
    parameter int unsigned RT_W   = 96,
    parameter int unsigned INCR_W = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [RT_W-1:0]   load_val,
    input  logic [INCR_W-1:0] incr,
    input  logic              snap_en,
    output logic [RT_W-1:0]   rt,
    output logic              moved
);
    typedef struct packed {
        logic [RT_W-1:0] rt;
        logic [RT_W-1:0] snap;
    } cnt_regs_t;

    cnt_regs_t q, d;

    always_comb begin
        d = q;
        if (load_en) begin
            d.rt = load_val;
        end else begin
            d.rt = q.rt + RT_W'(incr);
        end
        if (snap_en) begin
            d.snap = q.rt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rt    = q.rt;
    assign moved = (q.rt != q.snap);
endmodule

// File: rtl/tsc_pps_monitor.sv
module tsc_pps_monitor #(
    parameter int unsigned WIN_LOG2 = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_n,
    output logic fall,
    output logic active
);
    typedef struct packed {
        logic                prev;
        logic                active;
        logic [WIN_LOG2-1:0] cnt;
    } mon_regs_t;

    mon_regs_t q, d;
    logic      edge_now;

    always_comb begin
        edge_now = q.prev & ~pps_n;
        d        = q;
        d.prev   = pps_n;
        if (edge_now) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (q.active) begin
            if (&q.cnt) begin
                d.active = 1'b0;
                d.cnt    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{prev: 1'b1, active: 1'b0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign fall   = edge_now;
    assign active = q.active;
endmodule

// File: rtl/ts_counter_regs.sv
module ts_counter_regs
    import tsc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PSEL_W       = 8,
    parameter int unsigned CSEL_W       = 8,
    parameter int unsigned ACT_WIN_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              bus_ardy,
    output logic              bus_rvalid,
    input  logic              pps_n,
    input  logic [15:0]       pps_src_count,
    input  logic [15:0]       clk_src_count,
    input  logic [31:0]       clk_freq_code,
    output logic [PSEL_W-1:0] pps_sel,
    output logic [CSEL_W-1:0] clk_sel,
    output logic [63:0]       ts,
    output logic              ts_valid
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [STAGE_W-1:0] stage;
        logic [INCR_W-1:0]  incr;
        logic [RT_W-1:0]    cap;
        logic               tsv;
        logic [PSEL_W-1:0]  psel;
        logic [CSEL_W-1:0]  csel;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t             q, d;
    logic [WIDX_W-1:0] word_idx;
    logic [2:0]        op;
    logic              ctrl_wr;
    logic              load_rt;
    logic              snap_en;
    logic [RT_W-1:0]   rt_val;
    logic              moved;
    logic              pps_fall;
    logic              pps_act;
    logic [INCR_W-1:0] incr_val;
    logic [RT_W-1:0]   cap_val;
    logic [STAGE_W-1:0] stage_val;
    logic              unused_bits;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign op       = bus_wdata[2:0];
    assign ctrl_wr  = bus_wr && (word_idx == WIDX_W'(W_CTRL));
    assign load_rt  = ctrl_wr && (op == OP_LD_RT);
    assign snap_en  = bus_rd && (word_idx == WIDX_W'(W_STAT));
    assign unused_bits = ^{bus_be, bus_addr[1:0]};

    tsc_rt_counter #(
        .RT_W   (RT_W),
        .INCR_W (INCR_W)
    ) u_rt (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_rt),
        .load_val (q.stage),
        .incr     (q.incr),
        .snap_en  (snap_en),
        .rt       (rt_val),
        .moved    (moved)
    );

    tsc_pps_monitor #(
        .WIN_LOG2 (ACT_WIN_LOG2)
    ) u_pps (
        .clk    (clk),
        .rst    (rst),
        .pps_n  (pps_n),
        .fall   (pps_fall),
        .active (pps_act)
    );

    always_comb begin
        d        = q;
        d.rvalid = bus_rd;
        d.rdata  = '0;

        // read path
        if (bus_rd) begin
            for (int i = 0; i < int'(STAGE_WORDS); i++) begin
                if (word_idx == WIDX_W'(W_STG0 + i)) begin
                    d.rdata = q.stage[i*DATA_W +: DATA_W];
                end
            end
            case (word_idx)
                WIDX_W'(W_STAT): d.rdata = DATA_W'({moved, pps_act});
                WIDX_W'(W_PSEL): d.rdata = DATA_W'(q.psel);
                WIDX_W'(W_FREQ): d.rdata = clk_freq_code;
                WIDX_W'(W_CSEL): d.rdata = DATA_W'(q.csel);
                WIDX_W'(W_CNT):  d.rdata = {clk_src_count, pps_src_count};
                default: ;
            endcase
        end

        // write path
        if (bus_wr) begin
            for (int i = 0; i < int'(STAGE_WORDS); i++) begin
                if (word_idx == WIDX_W'(W_STG0 + i)) begin
                    d.stage[i*DATA_W +: DATA_W] = bus_wdata;
                end
            end
            case (word_idx)
                WIDX_W'(W_CTRL): begin
                    case (op)
                        OP_LD_INCR: d.incr  = q.stage[INCR_W-1:0];
                        OP_GET_INC: d.stage = STAGE_W'(q.incr);
                        OP_GET_RT:  d.stage = rt_val;
                        OP_GET_CAP: d.stage = q.cap;
                        default: ;
                    endcase
                end
                WIDX_W'(W_TSV):  d.tsv  = bus_wdata[0];
                WIDX_W'(W_PSEL): d.psel = bus_wdata[PSEL_W-1:0];
                WIDX_W'(W_CSEL): d.csel = bus_wdata[CSEL_W-1:0];
                default: ;
            endcase
        end

        // pulse capture
        if (pps_fall) begin
            d.cap = rt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign incr_val   = q.incr;
    assign cap_val    = q.cap;
    assign stage_val  = q.stage;
    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;
    assign bus_ardy   = 1'b1 | unused_bits;
    assign pps_sel    = q.psel;
    assign clk_sel    = q.csel;
    assign ts_valid   = q.tsv;
    assign ts         = rt_val[RT_W-1 -: TS_W];
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int unsigned WIDX_W = 6,
    parameter int unsigned RT_W   = 96,
    parameter int unsigned INCR_W = 39
) (
    input logic              clk,
    input logic              rst,
    input logic              rd,
    input logic              wr,
    input logic [WIDX_W-1:0] widx,
    input logic [2:0]        wop,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic              ts_valid,
    input logic [RT_W-1:0]   rt,
    input logic [INCR_W-1:0] incr,
    input logic [RT_W-1:0]   cap,
    input logic [RT_W-1:0]   stage,
    input logic              fall,
    input logic              act
);
    logic is_load;
    assign is_load = wr && (widx == WIDX_W'(3)) && (wop == 3'b001);

    a_r11_rvalid_after_rd: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (!rvalid && rdata == '0));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && widx > WIDX_W'(9)) |=> (rdata == '0));

    a_r4_rt_advance: assert property (@(posedge clk) disable iff (rst)
        !is_load |=> (rt == $past(rt) + RT_W'($past(incr))));

    a_r2_rt_load: assert property (@(posedge clk) disable iff (rst)
        is_load |=> (rt == $past(stage)));

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        fall |=> (cap == $past(rt)));

    a_r6_act_set: assert property (@(posedge clk) disable iff (rst)
        fall |=> act);

    a_r8_tsv_write: assert property (@(posedge clk) disable iff (rst)
        (wr && widx == WIDX_W'(5)) |=> (ts_valid == $past(wop[0])));
endmodule

bind ts_counter_regs tsc_checker #(
    .WIDX_W (ADDR_W - 2),
    .RT_W   (tsc_pkg::RT_W),
    .INCR_W (tsc_pkg::INCR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .widx     (bus_addr[ADDR_W-1:2]),
    .wop      (bus_wdata[2:0]),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid),
    .ts_valid (ts_valid),
    .rt       (rt_val),
    .incr     (incr_val),
    .cap      (cap_val),
    .stage    (stage_val),
    .fall     (pps_fall),
    .act      (pps_act)
);

// File: tb/sim_ts_counter_regs.sv
module sim_ts_counter_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        pps_n = 1'b1;
    logic [15:0] pps_cnt_in = 16'd3, clk_cnt_in = 16'd5;
    logic [31:0] freq_in = 32'd124999999;
    logic [31:0] bus_rdata;
    logic        bus_ardy, bus_rvalid, ts_valid;
    logic [7:0]  pps_sel, clk_sel;
    logic [63:0] ts;

    int n_chk = 0, n_fail = 0;
    bit live = 0, done = 0;

    always #4 clk = ~clk;

    ts_counter_regs u0 (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_be(be), .bus_rdata(bus_rdata), .bus_ardy(bus_ardy),
        .bus_rvalid(bus_rvalid), .pps_n(pps_n), .pps_src_count(pps_cnt_in),
        .clk_src_count(clk_cnt_in), .clk_freq_code(freq_in), .pps_sel(pps_sel),
        .clk_sel(clk_sel), .ts(ts), .ts_valid(ts_valid)
    );

    // ---------------- reference model, from the requirements ----------------
    logic [95:0] m_stage, m_rt, m_cap, m_snap;
    logic [38:0] m_incr;
    logic        m_tsv, m_prev, m_act, m_rvalid;
    logic [7:0]  m_psel, m_csel;
    logic [5:0]  m_cnt;
    logic [31:0] m_rdata;

    function automatic logic [31:0] mread(input logic [5:0] wi);
        case (wi)
            6'd0: return m_stage[31:0];
            6'd1: return m_stage[63:32];
            6'd2: return m_stage[95:64];
            6'd4: return {30'b0, (m_rt != m_snap), m_act};
            6'd6: return {24'b0, m_psel};
            6'd7: return freq_in;
            6'd8: return {24'b0, m_csel};
            6'd9: return {clk_cnt_in, pps_cnt_in};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [5:0] wi;
        wi = addr[7:2];
        if (rst) begin
            m_stage <= '0; m_rt <= '0; m_cap <= '0; m_snap <= '0; m_incr <= '0;
            m_tsv <= 0; m_prev <= 1; m_act <= 0; m_cnt <= '0; m_rvalid <= 0;
            m_psel <= '0; m_csel <= '0; m_rdata <= '0;
        end else begin
            m_rvalid <= rd;
            m_rdata  <= rd ? mread(wi) : 32'b0;
            if (rd && wi == 6'd4) m_snap <= m_rt;
            if (wr && wi == 6'd3 && wdata[2:0] == 3'b001) m_rt <= m_stage;
            else m_rt <= m_rt + {57'b0, m_incr};
            if (wr) begin
                case (wi)
                    6'd0: m_stage[31:0]  <= wdata;
                    6'd1: m_stage[63:32] <= wdata;
                    6'd2: m_stage[95:64] <= wdata;
                    6'd3: case (wdata[2:0])
                        3'b000: m_incr  <= m_stage[38:0];
                        3'b100: m_stage <= {57'b0, m_incr};
                        3'b101: m_stage <= m_rt;
                        3'b111: m_stage <= m_cap;
                        default: ;
                    endcase
                    6'd5: m_tsv  <= wdata[0];
                    6'd6: m_psel <= wdata[7:0];
                    6'd8: m_csel <= wdata[7:0];
                    default: ;
                endcase
            end
            if (m_prev && !pps_n) begin
                m_cap <= m_rt; m_act <= 1; m_cnt <= '0;
            end else if (m_act) begin
                if (m_cnt == 6'd63) begin m_act <= 0; m_cnt <= '0; end
                else m_cnt <= m_cnt + 1;
            end
            m_prev <= pps_n;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] wi);
        case (wi)
            6'd0, 6'd1, 6'd2: return "R1";
            6'd3: return "R2";
            6'd4: return "R6 R7";
            6'd5: return "R8";
            6'd6, 6'd8: return "R9";
            6'd7, 6'd9: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic per_cycle();
        if (!live) return;
        check(ts == m_rt[95:32], "R4 ts", {32'b0, ts}, {32'b0, m_rt[95:32]});
        check(ts_valid == m_tsv, "R8 ts_valid", {95'b0, ts_valid}, {95'b0, m_tsv});
        check(pps_sel == m_psel && clk_sel == m_csel, "R9 selects",
              {80'b0, pps_sel, clk_sel}, {80'b0, m_psel, m_csel});
        check(bus_rvalid == m_rvalid && bus_ardy, "R11 rvalid/ardy",
              {94'b0, bus_rvalid, bus_ardy}, {94'b0, m_rvalid, 1'b1});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        per_cycle();
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] dat);
        wr = 1; rd = 0; addr = a; wdata = dat; be = 4'($urandom);
        cyc();
        wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag, output logic [31:0] got);
        rd = 1; wr = 0; addr = a; be = 4'($urandom);
        cyc();
        rd = 0;
        got = bus_rdata;
        check(bus_rvalid === 1'b1 && bus_rdata === m_rdata, tag, {64'b0, bus_rdata}, {64'b0, m_rdata});
    endtask

    task automatic stage96(input logic [95:0] v);
        bus_write(8'h00, v[31:0]);
        bus_write(8'h04, v[63:32]);
        bus_write(8'h08, v[95:64]);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd4177));
        repeat (4) @(negedge clk);
        rst = 0;
        live = 1;
        // R12: reset state at the ports
        check(ts == 64'b0, "R12 ts", {32'b0, ts}, 96'b0);
        check(!ts_valid && pps_sel == 0 && clk_sel == 0 && !bus_rvalid, "R12 outputs",
              {77'b0, ts_valid, pps_sel, clk_sel, bus_rvalid}, 96'b0);
        cyc();
        // R7: zero step means no movement
        bus_read(8'h10, "R7 status zero step", got);
        check(got == 32'h0, "R7 status literal", {64'b0, got}, 96'h0);
        // R2: load step, then real-time near wrap
        stage96(96'h20);
        bus_write(8'h0C, 32'h0);
        stage96({64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFF0});
        bus_write(8'h0C, 32'h1);
        check(ts == 64'hFFFF_FFFF_FFFF_FFFF, "R2 load literal", {32'b0, ts}, {32'b0, 64'hFFFF_FFFF_FFFF_FFFF});
        cyc();
        check(ts == 64'h0, "R4 wrap literal", {32'b0, ts}, 96'h0);
        // R3: copy codes and no-op codes
        bus_write(8'h0C, 32'h4);
        bus_read(8'h00, "R3 step copy", got);
        check(got == 32'h20, "R3 step copy literal", {64'b0, got}, 96'h20);
        bus_write(8'h0C, 32'h5);
        bus_read(8'h00, "R3 rt copy", got);
        bus_read(8'h04, "R3 rt copy mid", got);
        bus_write(8'h0C, 32'h2);
        bus_write(8'h0C, 32'h3);
        bus_write(8'h0C, 32'h6);
        bus_read(8'h00, "R3 no-op codes", got);
        bus_write(8'h0C, 32'h4);
        bus_read(8'h00, "R3 step unchanged", got);
        check(got == 32'h20, "R3 step unchanged literal", {64'b0, got}, 96'h20);
        // R5, R6: pulse edge, capture, activity window
        pps_n = 0; cyc(); pps_n = 1; cyc();
        bus_read(8'h10, "R6 status after edge", got);
        check(got[0] == 1'b1, "R6 active literal", {95'b0, got[0]}, 96'h1);
        bus_write(8'h0C, 32'h7);
        bus_read(8'h00, "R5 capture low", got);
        bus_read(8'h04, "R5 capture mid", got);
        bus_read(8'h08, "R5 capture high", got);
        repeat (70) cyc();
        bus_read(8'h10, "R6 status after window", got);
        check(got[0] == 1'b0, "R6 cleared literal", {95'b0, got[0]}, 96'h0);
        check(got[1] == 1'b1, "R7 moved literal", {95'b0, got[1]}, 96'h1);
        // R8, R9, R10, R11
        bus_write(8'h14, 32'h1);
        bus_write(8'h18, 32'hABCD_12A5);
        bus_write(8'h20, 32'h0000_0103);
        bus_read(8'h18, "R9 pulse select", got);
        bus_read(8'h20, "R9 clock select", got);
        bus_read(8'h1C, "R10 frequency", got);
        bus_read(8'h24, "R10 counts", got);
        check(got == 32'h0005_0003, "R10 counts literal", {64'b0, got}, 96'h0005_0003);
        bus_read(8'h3E, "R11 unmapped", got);
        bus_read(8'h0D, "R11 low bits ignored", got);
        // random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [5:0] wi;
            r = $urandom % 10;
            if ($urandom % 40 == 0) pps_n = ~pps_n;
            if (n % 500 == 0) begin
                freq_in = $urandom; pps_cnt_in = 16'($urandom); clk_cnt_in = 16'($urandom);
            end
            if (r < 4) begin
                wi = 6'($urandom % 16);
                bus_read({wi, 2'($urandom)}, tag_of(wi), got);
            end else if (r < 8) begin
                wi = 6'($urandom % 10);
                bus_write({wi, 2'($urandom)}, (wi == 6'd3) ? 32'($urandom % 8) : $urandom);
            end else begin
                cyc();
            end
        end
        finish_up();
    end
endmodule